// File: doc/BRIEF.md
# SPI Burst Master

This block is a serial peripheral interface master that runs bursts of words. Software pushes words into a transmit FIFO, programs the word size, the number of words in the burst, the clock mode and which of four selects to use, and then sets the exchange bit. The engine asserts the chosen select, shifts every word out most-significant bit first while it samples the return line, and places each received word into a receive FIFO. When the last word has shifted, the select is released and a sticky transfer-complete flag is raised.

The select is driven only while a burst is running. It is released between bursts, so it acts as a frame strobe for one burst, not for a whole message. Both the word size and the burst length are written as the value minus one. The serial clock rate comes from outside: a separate generator supplies a one-cycle enable pulse for every half period of the serial clock. If the transmit FIFO runs dry in the middle of a burst, the engine waits with the clock parked at its idle level until software supplies the next word.

A small word-addressed register port gives access to the two FIFOs, the control word, an interrupt mask, the status flags and a FIFO flush strobe.

Top module: `spi_burst_master`

## Requirements
- R1: The register word addresses are 0 receive data (a read pops), 1 transmit data (a write pushes), 2 control, 3 interrupt mask, 4 status, 5 flush. After reset, status reads 0x01, control reads 0, the serial clock is low, every select is inactive (high) and the interrupt is low.
- R2: The control fields are: enable bit 0, master bit 1, exchange bit 2, clock polarity bit 4, clock phase bit 5, select polarity bit 7 (1 = active high), select index bits 13:12, word size minus one bits 24:19, and words minus one bits 31:25. During a burst only the indexed select is at its active level.
- R3: Each word is bits 24:19 plus one bits long (8, 16, 24 and 32 all work). It is sent most-significant bit first from the low bits of the transmit word. Each received word is right-aligned and zero-extended, and words are read out in the order they were shifted in.
- R4: The serial clock idles at the polarity bit. With phase 0, the first data bit is on the output before the first edge and the input is sampled on leading edges. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R5: A burst moves the words-minus-one field plus one words, clamped to the FIFO depth of 16. Afterwards the select returns to inactive and status bit 7 (transfer complete) is set.
- R6: When the transmit FIFO is empty between words of an unfinished burst, the engine stalls: the select stays asserted, the clock stays at idle, and the burst resumes when a word is pushed.
- R7: Writing 1 to status bit 7 clears transfer complete. Writing 0 there leaves it unchanged.
- R8: The status bits are: 0 TX empty, 1 TX at least half full (8 or more words), 2 TX full, 3 RX not empty, 4 RX at least half full, 5 RX full, 6 RX overflow, 7 transfer complete. Overflow is set when a received word meets a full RX FIFO; the word is dropped and the flag stays set until a 1 is written to bit 6. A push to a full TX FIFO is dropped.
- R9: The interrupt output is high exactly when some status bit and its bit in the interrupt mask are both 1.
- R10: Writing 1 to bit 0 of the flush address empties both FIFOs. The sticky flags are not affected.
- R11: Setting the exchange bit while a burst runs has no effect. Control bit 2 reads 1 while a burst runs and 0 after it ends.
- R12: A write that sets the exchange bit starts nothing unless the same write also sets both enable and master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at address 0) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sclk_tick | input | 1 | Half-period enable from the clock generator |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Select lines, level set by the polarity bit |
| irq | output | 1 | Masked status interrupt |

## Verification
The checker watches these on every cycle: at most one select is active, the clock returns to the polarity level whenever the engine is idle, the clock does not move while a stall lasts, a finished burst always leaves the engine idle with transfer complete set, and neither FIFO fill count goes past the depth. Some properties need a remote device and software to show them, so only the bench scenarios can demonstrate them. These are bit ordering and right alignment for each clock mode and word size, the clamping of burst length, word order across a multi-word burst, overflow dropping, ignored exchange requests, and the status codes that the sticky flags and the flush produce.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  // register word addresses
  localparam logic [2:0] A_RXD   = 3'd0;
  localparam logic [2:0] A_TXD   = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_FLUSH = 3'd5;

  // control word field positions
  localparam int C_EN       = 0;
  localparam int C_MS       = 1;
  localparam int C_XCH      = 2;
  localparam int C_CPOL     = 4;
  localparam int C_CPHA     = 5;
  localparam int C_CSPOL    = 7;
  localparam int C_CSIDX_LO = 12;
  localparam int C_BL_LO    = 19;
  localparam int C_BL_W     = 6;
  localparam int C_BUR_LO   = 25;
  localparam int C_BUR_W    = 7;

  // status bit positions
  localparam int S_TXE = 0;
  localparam int S_TXH = 1;
  localparam int S_TXF = 2;
  localparam int S_RXR = 3;
  localparam int S_RXH = 4;
  localparam int S_RXF = 5;
  localparam int S_RXO = 6;
  localparam int S_TC  = 7;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_LOAD  = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign count   = cnt_q;
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset; written only under its clock enable
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [IDX_W-1:0]  bit_last,
  input  logic [CNT_W-1:0]  words_last,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              in_load,
  output logic              done,
  output logic              sck,
  output logic              mosi
);
  eng_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic [DATA_W-1:0] txw_q, txw_d, rxw_q, rxw_d, rx_shift;
  logic              sck_q, sck_d, mosi_q, mosi_d, half_q, half_d;

  assign rx_shift = {rxw_q[DATA_W-2:0], miso};
  assign rx_data  = cpha ? rx_shift : rxw_q;
  assign busy     = (state_q != ENG_IDLE);
  assign in_load  = (state_q == ENG_LOAD);
  assign sck      = sck_q;
  assign mosi     = mosi_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wcnt_d  = wcnt_q;
    txw_d   = txw_q;
    rxw_d   = rxw_q;
    sck_d   = sck_q;
    mosi_d  = mosi_q;
    half_d  = half_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        sck_d = cpol;
        if (start) begin
          state_d = ENG_LOAD;
          wcnt_d  = '0;
        end
      end
      ENG_LOAD: begin
        sck_d = cpol;
        if (!tx_empty) begin
          tx_pop  = 1'b1;
          txw_d   = tx_data;
          rxw_d   = '0;
          idx_d   = bit_last;
          half_d  = 1'b0;
          if (!cpha) mosi_d = tx_data[bit_last];
          state_d = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          if (!half_q) begin
            // leading edge
            sck_d  = ~cpol;
            half_d = 1'b1;
            if (cpha) mosi_d = txw_q[idx_q];
            else      rxw_d  = rx_shift;
          end else begin
            // trailing edge
            sck_d  = cpol;
            half_d = 1'b0;
            if (cpha) rxw_d = rx_shift;
            if (idx_q == '0) begin
              rx_push = 1'b1;
              if (wcnt_q == words_last) begin
                done    = 1'b1;
                state_d = ENG_IDLE;
              end else begin
                wcnt_d  = wcnt_q + 1'b1;
                state_d = ENG_LOAD;
              end
            end else begin
              idx_d = idx_q - 1'b1;
              if (!cpha) mosi_d = txw_q[idx_q - 1'b1];
            end
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      txw_q   <= '0;
      rxw_q   <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
      txw_q   <= txw_d;
      rxw_q   <= rxw_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
      half_q  <= half_d;
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_bm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sclk_tick,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs,
  output logic              irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH) + 1;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CSI_W  = $clog2(NUM_CS);

  logic [31:0]       ctrl_q, ctrl_d;
  logic [7:0]        ien_q, ien_d;
  logic              tc_q, tc_d, ro_q, ro_d;
  logic [7:0]        status;

  logic              wr_ctrl, wr_stat, wr_txd, wr_flush, rd_rxd;
  logic              start_req, flush;
  logic              cfg_cpol, cfg_cpha, cfg_cspol;
  logic [CSI_W-1:0]  cfg_csidx;
  logic [C_BL_W-1:0] bl_field;
  logic [C_BUR_W-1:0] bur_field;
  logic [IDX_W-1:0]  bit_last;
  logic [CNT_W-1:0]  words_last;

  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push;
  logic              eng_busy, eng_done, eng_in_load;

  // ---------------- register decode ----------------
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_txd   = reg_wr && (reg_addr == A_TXD);
  assign wr_flush = reg_wr && (reg_addr == A_FLUSH);
  assign rd_rxd   = reg_rd && (reg_addr == A_RXD);
  assign flush    = wr_flush && reg_wdata[0];
  assign start_req = wr_ctrl && reg_wdata[C_XCH] && reg_wdata[C_EN]
                     && reg_wdata[C_MS] && !eng_busy;

  assign cfg_cpol  = ctrl_q[C_CPOL];
  assign cfg_cpha  = ctrl_q[C_CPHA];
  assign cfg_cspol = ctrl_q[C_CSPOL];
  assign cfg_csidx = ctrl_q[C_CSIDX_LO +: CSI_W];
  assign bl_field  = ctrl_q[C_BL_LO +: C_BL_W];
  assign bur_field = ctrl_q[C_BUR_LO +: C_BUR_W];

  // clamp programmed word size and burst length to what the datapath holds
  assign bit_last   = (32'(bl_field) > DATA_W - 1) ? IDX_W'(DATA_W - 1)
                                                    : bl_field[IDX_W-1:0];
  assign words_last = (32'(bur_field) > FIFO_DEPTH - 1) ? CNT_W'(FIFO_DEPTH - 1)
                                                         : CNT_W'(bur_field);

  always_comb begin
    ctrl_d = ctrl_q;
    ien_d  = ien_q;
    tc_d   = tc_q;
    ro_d   = ro_q;
    if (wr_ctrl) ctrl_d = reg_wdata & ~(32'd1 << C_XCH);
    if (reg_wr && (reg_addr == A_IEN)) ien_d = reg_wdata[7:0];
    if (wr_stat && reg_wdata[S_TC])  tc_d = 1'b0;
    if (wr_stat && reg_wdata[S_RXO]) ro_d = 1'b0;
    if (eng_done)           tc_d = 1'b1;
    if (rx_push && rx_full) ro_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      tc_q   <= 1'b0;
      ro_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      tc_q   <= tc_d;
      ro_q   <= ro_d;
    end
  end

  // ---------------- status and interrupt ----------------
  always_comb begin
    status        = '0;
    status[S_TXE] = tx_empty;
    status[S_TXH] = (tx_cnt >= CNT_W'(FIFO_DEPTH / 2));
    status[S_TXF] = tx_full;
    status[S_RXR] = !rx_empty;
    status[S_RXH] = (rx_cnt >= CNT_W'(FIFO_DEPTH / 2));
    status[S_RXF] = rx_full;
    status[S_RXO] = ro_q;
    status[S_TC]  = tc_q;
  end

  assign irq = |(status & ien_q);

  always_comb begin
    unique case (reg_addr)
      A_RXD:   reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      A_CTRL:  reg_rdata = ctrl_q | (32'(eng_busy) << C_XCH);
      A_IEN:   reg_rdata = {24'd0, ien_q};
      A_STAT:  reg_rdata = {24'd0, status};
      default: reg_rdata = 32'd0;
    endcase
  end

  // ---------------- FIFOs ----------------
  spi_bm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_txd), .wdata(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop), .rdata(tx_head),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_bm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .wdata(rx_word),
    .pop(rd_rxd), .rdata(rx_head),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  // ---------------- shift engine ----------------
  spi_bm_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .tick(sclk_tick), .start(start_req),
    .cpol(cfg_cpol), .cpha(cfg_cpha),
    .bit_last(bit_last), .words_last(words_last),
    .tx_empty(tx_empty), .tx_data(tx_head), .miso(spi_miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
    .busy(eng_busy), .in_load(eng_in_load), .done(eng_done),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  // ---------------- selects: active only while a burst runs ----------------
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs[g] = (eng_busy && (cfg_csidx == CSI_W'(g))) ? cfg_cspol : ~cfg_cspol;
  end
endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 5,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              in_load,
  input logic              tx_empty,
  input logic              sck,
  input logic              cpol,
  input logic              cspol,
  input logic              tc,
  input logic [NUM_CS-1:0] cs,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs ^ {NUM_CS{~cspol}}));

  a_r4_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || sck == $past(cpol)));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r5_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tc);

  a_r6_stall_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && tx_empty) |=> (sck == $past(sck)));

  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));
endmodule

bind spi_burst_master spi_bm_checker #(
  .NUM_CS(NUM_CS), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done(eng_done),
  .in_load(eng_in_load), .tx_empty(tx_empty), .sck(spi_sck),
  .cpol(cfg_cpol), .cspol(cfg_cspol), .tc(tc_q), .cs(spi_cs),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  logic        clk, rst_n, reg_wr, reg_rd, sclk_tick, spi_miso;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sck, spi_mosi, irq;
  logic [3:0]  spi_cs;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the remote device
  logic        s_on, s_cpol, s_cpha, s_first;
  logic [31:0] s_stream, s_cap;
  assign spi_miso = s_stream[31];

  spi_burst_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_tick(sclk_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs(spi_cs), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    sclk_tick = 1'b0;
    forever begin
      @(posedge clk);
      sclk_tick <= ~sclk_tick;
    end
  end

  // remote device: samples and shifts on the edges its mode defines
  initial begin
    s_on = 0; s_cpol = 0; s_cpha = 0; s_first = 1; s_stream = '0; s_cap = '0;
    forever begin
      @(spi_sck);
      if (s_on) begin
        if ((spi_sck != s_cpol) ^ s_cpha) s_cap = {s_cap[30:0], spi_mosi};
        else if (s_cpha && s_first) s_first = 0;
        else s_stream = s_stream << 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic en, input logic xch, input logic cpol,
                                     input logic cpha, input logic cspol, input logic [1:0] csi,
                                     input logic [5:0] bl, input logic [6:0] bur);
    return {bur, bl, 5'd0, csi, 4'd0, cspol, 1'b0, cpha, cpol, 1'b0, xch, 1'b1, en};
  endfunction

  task automatic wait_tc(input string tag);
    logic [31:0] d;
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      rd(3'd4, d);
      if (d[7]) seen = 1;
    end
    check({tag, " burst completes"}, 32'(seen), 32'd1);
  endtask

  // {cpol, cpha, size-1, word sent, word returned by remote}
  localparam logic [71:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd7,  32'h000000A5, 32'h0000003C},
    {1'b0, 1'b1, 6'd15, 32'h00001234, 32'h0000BEEF},
    {1'b1, 1'b0, 6'd23, 32'h00ABCDEF, 32'h00135790},
    {1'b1, 1'b1, 6'd31, 32'hDEADBEEF, 32'h0F1E2D3C},
    {1'b0, 1'b0, 6'd31, 32'h80000001, 32'hC0FFEE11},
    {1'b1, 1'b1, 6'd7,  32'h0000005A, 32'h00000081}
  };

  initial begin
    logic [31:0] d, cfg, mask;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(3'd4, d);   check("R1 status after reset", d, 32'h01);
    rd(3'd2, d);   check("R1 control after reset", d, 32'h0);
    check("R1 clock idle low", 32'(spi_sck), 32'd0);
    check("R1 selects inactive", 32'(spi_cs), 32'hF);
    check("R1 irq low", 32'(irq), 32'd0);

    // R3 R4: modes and word sizes from the vector table
    foreach (VEC[i]) begin
      logic [71:0] v;
      v = VEC[i];
      mask = (v[69:64] == 6'd31) ? 32'hFFFFFFFF : ((32'd1 << (v[69:64] + 1)) - 1);
      cfg = mk(1, 0, v[71], v[70], 0, 2'd0, v[69:64], 7'd0);
      wr(3'd2, cfg);
      wr(3'd1, v[63:32]);
      s_cpol = v[71]; s_cpha = v[70]; s_first = 1; s_cap = '0;
      s_stream = v[31:0] << (31 - v[69:64]);
      s_on = 1;
      wr(3'd2, cfg | 32'h4);
      wait_tc($sformatf("R4 vec%0d", i));
      s_on = 0;
      rd(3'd0, d);
      check($sformatf("R3 R4 vec%0d received word", i), d, v[31:0] & mask);
      check($sformatf("R3 R4 vec%0d word seen by remote", i), s_cap & mask, v[63:32] & mask);
      wr(3'd4, 32'h80);
    end

    // R3 R5: three-word burst keeps order
    cfg = mk(1, 0, 0, 0, 0, 2'd0, 6'd7, 7'd2);
    wr(3'd2, cfg);
    wr(3'd1, 32'h11); wr(3'd1, 32'h22); wr(3'd1, 32'h33);
    s_cpol = 0; s_cpha = 0; s_first = 1; s_cap = '0; s_stream = 32'hA1B2C300;
    s_on = 1;
    wr(3'd2, cfg | 32'h4);
    wait_tc("R5 three words");
    s_on = 0;
    check("R3 remote got words in order", s_cap, 32'h00112233);
    rd(3'd0, d); check("R3 first word out", d, 32'hA1);
    rd(3'd0, d); check("R3 second word out", d, 32'hB2);
    rd(3'd0, d); check("R3 third word out", d, 32'hC3);
    wr(3'd4, 32'h80);

    // R2 R6 R11: select index and polarity, stall on empty TX, ignored exchange
    cfg = mk(1, 0, 1, 0, 1, 2'd2, 6'd7, 7'd1);
    wr(3'd2, cfg);
    wr(3'd1, 32'h11);
    wr(3'd2, cfg | 32'h4);
    repeat (80) @(posedge clk);
    @(negedge clk);
    check("R2 only select 2 active high", 32'(spi_cs), 32'h4);
    check("R6 clock parked at idle in stall", 32'(spi_sck), 32'd1);
    rd(3'd4, d); check("R6 no completion while stalled", 32'(d[7]), 32'd0);
    rd(3'd2, d); check("R11 exchange reads 1 while busy", 32'(d[2]), 32'd1);
    wr(3'd2, cfg | 32'h4);
    wr(3'd1, 32'h22);
    wait_tc("R6 resume");
    check("R5 selects released after burst", 32'(spi_cs), 32'h0);
    rd(3'd2, d); check("R11 exchange reads 0 after burst", 32'(d[2]), 32'd0);
    wr(3'd4, 32'h00);
    rd(3'd4, d); check("R7 writing 0 keeps complete", 32'(d[7]), 32'd1);
    wr(3'd4, 32'h80);
    repeat (200) @(posedge clk);
    rd(3'd4, d); check("R11 R7 no second burst, complete cleared", d, 32'h09);
    wr(3'd5, 32'h1);
    rd(3'd4, d); check("R10 flush empties RX", d, 32'h01);

    // R5 R8: burst clamp to 16 words, TX full drop, RX full and overflow
    cfg = mk(1, 0, 0, 0, 0, 2'd0, 6'd7, 7'd127);
    wr(3'd2, cfg);
    for (int k = 0; k < 17; k++) wr(3'd1, 32'(k));
    rd(3'd4, d); check("R8 TX full and half", d, 32'h06);
    wr(3'd2, cfg | 32'h4);
    wait_tc("R5 clamp");
    repeat (100) @(posedge clk);
    rd(3'd4, d); check("R5 R8 sixteen words moved", d, 32'hB9);
    wr(3'd4, 32'h80);
    cfg = mk(1, 0, 0, 0, 0, 2'd0, 6'd7, 7'd0);
    wr(3'd2, cfg);
    wr(3'd1, 32'h5);
    wr(3'd2, cfg | 32'h4);
    wait_tc("R8 overflow burst");
    rd(3'd4, d); check("R8 overflow flagged", d, 32'hF9);

    // R9 interrupt masking
    wr(3'd3, 32'h40); @(negedge clk);
    check("R9 irq on masked overflow", 32'(irq), 32'd1);
    wr(3'd3, 32'h02); @(negedge clk);
    check("R9 irq low when enabled bit clear", 32'(irq), 32'd0);
    wr(3'd3, 32'h00);

    // R10 flush keeps sticky flags
    wr(3'd1, 32'h1); wr(3'd1, 32'h2); wr(3'd1, 32'h3);
    wr(3'd5, 32'h1);
    rd(3'd4, d); check("R10 flush empties both FIFOs", d, 32'hC1);
    wr(3'd4, 32'hC0);
    rd(3'd4, d); check("R8 overflow cleared by write 1", d, 32'h01);

    // R12 exchange without enable starts nothing
    wr(3'd1, 32'h7);
    wr(3'd2, mk(0, 1, 0, 0, 0, 2'd0, 6'd7, 7'd0));
    repeat (60) @(posedge clk);
    @(negedge clk);
    check("R12 selects stay inactive", 32'(spi_cs), 32'hF);
    rd(3'd4, d); check("R12 word left in TX, no completion", d, 32'h00);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule